// File: doc/BRIEF.md
# I2C Single-Master Segment Engine

This block drives an I2C bus as its only master and moves one segment per command. A segment is up to four bytes, sent or received through one 32-bit data register. A command can open the segment with a START and close it with a STOP. If a segment ends without STOP and the command asks for it, SCL stays low so that the bus is kept. A longer message is therefore split into several commands. Only the first command carries START, and the rest continue on the same bus ownership without a repeated START.

Software prepares a command word with the run bit clear, loads the data word, and then writes the command again with the run bit set. The engine clears run when the segment ends. Sticky event flags, each with its own enable onto one interrupt line, report these events:

- completion
- bus release
- a missing acknowledge
- early termination
- lost arbitration
- a data write refused while busy

A missing acknowledge also freezes the engine until a separate clear pulse arrives. SCL and SDA are open-drain: the block only ever pulls a line low and reads it back. All control and status pins are plain levels or pulses. There is no handshake on any port.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command write with bit 29 (run) set while idle starts a segment. The run output is high from the next cycle until the segment ends, then reads 0, and flag bit 6 (done) is set.
- R2: With bit 16 = 1 (transmit), the engine sends exactly count (bits [15:0]) bytes from the data word, lane [7:0] first and MSB first within a byte. It emits a START beforehand only when bit 19 is set.
- R3: With bit 20 set, the segment ends with a STOP. Both lines are released high, flag bit 7 (bus free) is set and bus_busy clears.
- R4: With bit 21 set and bit 20 clear, SCL is held low after the segment. A following segment with bit 19 clear continues without any START condition.
- R5: With bit 16 = 0 (receive), count bytes are captured into the data register with the first byte in bits [7:0]. Lanes not received read as zero.
- R6: In a receive segment with bit 25 set, the master ACKs every byte except the last, which it NAKs.
- R7: A missing acknowledge during transmit has the following effects:
  - got_nak is set, flag bit 5 is set and run clears.
  - No STOP is sent.
  - Any further run command is ignored until a nak_clr pulse.
- R8: A run command with count 0, count above 4, or bit 17 (master enable) clear causes no bus activity. Run stays 0 and flag bit 4 (early end) is set.
- R9: If SDA reads low while the engine releases it for a transmitted 1 bit, flag bit 3 (arbitration lost) is set. Both lines are released and run and bus_busy clear.
- R10: A data register write while run is high is ignored and sets flag bit 0.
- R11: Flags are sticky until a 1 is written to their bit of flag_clr. irq is the OR of flags ANDed with irq_en.
- R12: After reset, run, got_nak, bus_busy, clk_busy and all flags are 0, and neither line is pulled low.
- R13: clk_busy is high while a segment is being clocked and low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data word to transmit |
| data_rdata | output | 32 | Data register contents (TX word or received bytes) |
| nak_clr | input | 1 | Pulse that releases the NAK halt |
| flag_clr | input | 8 | Write-one-to-clear for flags |
| irq_en | input | 8 | Per-flag interrupt enables |
| flags | output | 8 | Sticky event flags |
| irq | output | 1 | Interrupt request |
| run | output | 1 | Segment in progress |
| got_nak | output | 1 | Sticky missing-acknowledge status |
| bus_busy | output | 1 | Bus owned between START and STOP |
| clk_busy | output | 1 | Engine currently generating SCL |
| scl_in | input | 1 | Sensed SCL line |
| sda_in | input | 1 | Sensed SDA line |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |

## Verification
Three kinds of result become visible at different times after a stimulus:

- **Results tied to a command write.** A run start, an early end, a refused data write and a halted run request are registered on the first rising edge after the strobe. The bench samples them on the very next falling edge.
- **Bus results.** Each SCL phase lasts DIV clocks, so a segment takes (4 + 36·count + 4)·DIV cycles. Rather than count to that cycle, the bench polls run on falling edges until it drops. Done, NAK, arbitration and bus-free flags are set on the same edge that clears run, so they are read on that falling edge together with the line levels and the slave model's byte log.
- **Clearing.** Flag clears and nak_clr act on one edge and are checked on the following falling edge.

// File: rtl/icm_pkg.sv
package icm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} icm_state_e;

  // command word bit positions
  localparam int CB_DIR     = 16;
  localparam int CB_MASTER  = 17;
  localparam int CB_START   = 19;
  localparam int CB_STOP    = 20;
  localparam int CB_RETAIN  = 21;
  localparam int CB_NAKLAST = 25;
  localparam int CB_RUN     = 29;

  // flag bit positions
  localparam int FL_WERR  = 0;
  localparam int FL_ARB   = 3;
  localparam int FL_EARLY = 4;
  localparam int FL_NAK   = 5;
  localparam int FL_DONE  = 6;
  localparam int FL_FREE  = 7;
endpackage

// File: rtl/icm_tick.sv
module icm_tick #(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [TW-1:0] cnt;

  assign tick = en && (cnt == TW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || !en || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/icm_flags.sv
module icm_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] flags_q,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags_q[i] <= 1'b0;
      else if (set[i]) flags_q[i] <= 1'b1;
      else if (clr[i]) flags_q[i] <= 1'b0;
    end
  end

  assign irq = |(flags_q & en);

  // R11: a flag not cleared stays set
  assert_flags_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~clr)) == $past(flags_q & ~clr)));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import icm_pkg::*;
#(
  parameter int DIV    = 5,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] data_rdata,
  input  logic              nak_clr,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic [FLAG_W-1:0] irq_en,
  output logic [FLAG_W-1:0] flags,
  output logic              irq,
  output logic              run,
  output logic              got_nak,
  output logic              bus_busy,
  output logic              clk_busy,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);
  localparam int NBYTES = DATA_W / 8;
  localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  icm_state_e        st;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic [BI_W-1:0]   byten, cnt_m1;
  logic              dir_q, stop_q, retain_q, naklast_q;
  logic [DATA_W-1:0] data_q;
  logic [7:0]        rx_sh;
  logic              scl_lo, sda_lo, run_q, nak_q, busy_q;
  logic              tick;
  logic [FLAG_W-1:0] fset;

  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd_wdata[31:30], cmd_wdata[28:26], cmd_wdata[24:22],
                             cmd_wdata[18], scl_in};

  // command decode
  wire [CNT_W-1:0] req_cnt   = cmd_wdata[CNT_W-1:0];
  wire             start_req = cmd_we && cmd_wdata[CB_RUN] && !run_q && !nak_q;
  wire             bad_cmd   = (req_cnt == '0) || (req_cnt > CNT_W'(NBYTES)) ||
                               !cmd_wdata[CB_MASTER];
  wire             launch    = start_req && !bad_cmd;
  wire             early     = start_req && bad_cmd;

  // bit level
  wire [7:0] cur_byte  = data_q[{byten, 3'b000} +: 8];
  wire       tx_bit    = cur_byte[3'd7 - bitn[2:0]];
  wire       last_byte = (byten == cnt_m1);
  wire       sample    = tick && (ph == 2'd3);
  wire       in_bit    = (st == ST_BIT);
  wire       ack_slot  = (bitn == 4'd8);
  wire       ev_arb    = sample && in_bit && !ack_slot && dir_q && tx_bit && !sda_in;
  wire       ev_nak    = sample && in_bit && ack_slot && dir_q && sda_in;
  wire       byte_end  = sample && in_bit && ack_slot && !ev_nak;
  wire       ev_stop   = sample && (st == ST_STOP);
  wire       ev_done   = (byte_end && last_byte && !stop_q) || ev_stop;

  logic drive_bit;
  always_comb begin
    if (!ack_slot) drive_bit = dir_q ? !tx_bit : 1'b0;
    else           drive_bit = dir_q ? 1'b0 : !(last_byte && naklast_q);
  end

  icm_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(launch), .en(st != ST_IDLE), .tick(tick)
  );

  always_comb begin
    fset           = '0;
    fset[FL_WERR]  = data_we && run_q;
    fset[FL_ARB]   = ev_arb;
    fset[FL_EARLY] = early;
    fset[FL_NAK]   = ev_nak;
    fset[FL_DONE]  = ev_done;
    fset[FL_FREE]  = ev_stop;
  end

  icm_flags #(.W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(fset), .clr(flag_clr), .en(irq_en),
    .flags_q(flags), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  ph <= '0;  bitn <= '0;  byten <= '0;  cnt_m1 <= '0;
      dir_q <= 1'b0;  stop_q <= 1'b0;  retain_q <= 1'b0;  naklast_q <= 1'b0;
      data_q <= '0;  rx_sh <= '0;  scl_lo <= 1'b0;  sda_lo <= 1'b0;
      run_q <= 1'b0;  nak_q <= 1'b0;  busy_q <= 1'b0;
    end else begin
      if (nak_clr) nak_q <= 1'b0;
      if (data_we && !run_q) data_q <= data_wdata;
      if (launch) begin
        run_q     <= 1'b1;
        dir_q     <= cmd_wdata[CB_DIR];
        stop_q    <= cmd_wdata[CB_STOP];
        retain_q  <= cmd_wdata[CB_RETAIN];
        naklast_q <= cmd_wdata[CB_NAKLAST];
        cnt_m1    <= BI_W'(req_cnt - 1'b1);
        st        <= cmd_wdata[CB_START] ? ST_START : ST_BIT;
        ph <= '0;  bitn <= '0;  byten <= '0;
        if (!cmd_wdata[CB_DIR]) data_q <= '0;
      end else if (tick) begin
        ph <= ph + 1'b1;
        unique case (st)
          ST_START: begin
            unique case (ph)
              2'd0: if (busy_q) scl_lo <= 1'b1;
              2'd1: sda_lo <= 1'b0;
              2'd2: scl_lo <= 1'b0;
              default: begin
                sda_lo <= 1'b1;
                busy_q <= 1'b1;
                st     <= ST_BIT;
                bitn   <= '0;
              end
            endcase
          end
          ST_BIT: begin
            unique case (ph)
              2'd0: scl_lo <= 1'b1;
              2'd1: sda_lo <= drive_bit;
              2'd2: scl_lo <= 1'b0;
              default: begin
                if (ev_arb) begin
                  scl_lo <= 1'b0;  sda_lo <= 1'b0;
                  busy_q <= 1'b0;  run_q  <= 1'b0;  st <= ST_IDLE;
                end else if (ev_nak) begin
                  nak_q <= 1'b1;  run_q <= 1'b0;  st <= ST_IDLE;
                end else if (ack_slot) begin
                  if (!dir_q) data_q[{byten, 3'b000} +: 8] <= rx_sh;
                  if (last_byte) begin
                    if (stop_q) st <= ST_STOP;
                    else begin
                      scl_lo <= retain_q;  run_q <= 1'b0;  st <= ST_IDLE;
                    end
                  end else begin
                    byten <= byten + 1'b1;
                    bitn  <= '0;
                  end
                end else begin
                  bitn <= bitn + 1'b1;
                  if (!dir_q) rx_sh <= {rx_sh[6:0], sda_in};
                end
              end
            endcase
          end
          ST_STOP: begin
            unique case (ph)
              2'd0: scl_lo <= 1'b1;
              2'd1: sda_lo <= 1'b1;
              2'd2: scl_lo <= 1'b0;
              default: begin
                sda_lo <= 1'b0;  busy_q <= 1'b0;  run_q <= 1'b0;  st <= ST_IDLE;
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign data_rdata    = data_q;
  assign run           = run_q;
  assign got_nak       = nak_q;
  assign bus_busy      = busy_q;
  assign clk_busy      = (st != ST_IDLE);
  assign scl_drive_low = scl_lo;
  assign sda_drive_low = sda_lo;

  // R7: halted engine never starts a segment
  assert_halt_blocks_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_q && !run_q && !nak_clr) |=> !run_q);
  // R2: within a bit, SDA moves only while SCL is held low
  assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT && $past(st) == ST_BIT && !scl_lo && !$past(scl_lo)) |-> $stable(sda_lo));
  // R10: refused write keeps the transmit word
  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && run_q && dir_q) |=> $stable(data_q));
  // R8: bad command never enters the engine
  assert_early_no_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> (!run_q && st == ST_IDLE && flags[FL_EARLY]));
  // R2: bit index never passes the acknowledge slot
  assert_bit_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BIT) |-> (bitn <= 4'd8));
endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0, data_we = 1'b0, nak_clr = 1'b0;
  logic [31:0] cmd_wdata = '0, data_wdata = '0;
  logic [7:0]  flag_clr = '0, irq_en = '0;
  wire  [31:0] data_rdata;
  wire  [7:0]  flags;
  wire         irq, run, got_nak, bus_busy, clk_busy, scl_dl, sda_dl;
  logic        s_low = 1'b0, jam = 1'b0, log_clr = 1'b0;
  int          nak_at = 255;

  wire scl_w = scl_dl ? 1'b0 : 1'b1;
  wire sda_w = (sda_dl || s_low || jam) ? 1'b0 : 1'b1;

  always #5 clk = ~clk;

  i2c_cmd_master u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .nak_clr(nak_clr), .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags),
    .irq(irq), .run(run), .got_nak(got_nak), .bus_busy(bus_busy),
    .clk_busy(clk_busy), .scl_in(scl_w), .sda_in(sda_w),
    .scl_drive_low(scl_dl), .sda_drive_low(sda_dl)
  );

  // slave model, sampled on falling clock edges
  logic       p_scl = 1'b1, p_sda = 1'b1, act = 1'b0, rdm = 1'b0, pend = 1'b0, mack = 1'b0;
  int         bc = 0, bno = 0, rcount = 0, start_cnt = 0, nlog = 0, nm = 0;
  logic [7:0] sh = '0, rcur = '0;
  logic [7:0] rxlog [16];
  logic       mlog [8];

  always @(negedge clk) begin
    logic [7:0] v;
    if (log_clr) begin nlog <= 0; nm <= 0; end
    if (p_scl && scl_w && p_sda && !sda_w) begin
      act <= 1'b1; bc <= 0; bno <= 0; rdm <= 1'b0; pend <= 1'b0; rcount <= 0;
      s_low <= 1'b0; start_cnt <= start_cnt + 1;
    end else if (p_scl && scl_w && !p_sda && sda_w) begin
      act <= 1'b0; s_low <= 1'b0;
    end else if (act && !p_scl && scl_w) begin
      if (bc < 8) sh <= {sh[6:0], sda_w};
      else begin
        mack <= sda_w;
        if (rdm && nm < 8) begin mlog[nm] <= sda_w; nm <= nm + 1; end
      end
      bc <= bc + 1;
    end else if (act && p_scl && !scl_w) begin
      if (bc == 8) begin
        if (!rdm) begin
          if (nlog < 16) begin rxlog[nlog] <= sh; nlog <= nlog + 1; end
          s_low <= (bno != nak_at);
          if (bno == 0 && sh[0]) pend <= 1'b1;
        end else s_low <= 1'b0;
      end else if (bc == 9) begin
        bc <= 0; bno <= bno + 1;
        if (pend || (rdm && !mack)) begin
          v = 8'h5A + 8'(rcount * 17);
          rdm <= 1'b1; pend <= 1'b0; rcur <= v; s_low <= ~v[7]; rcount <= rcount + 1;
        end else begin
          rdm <= 1'b0; s_low <= 1'b0;
        end
      end else if (rdm && bc >= 1 && bc <= 7) s_low <= ~rcur[7 - bc];
    end
    p_scl <= scl_w; p_sda <= sda_w;
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic done_all = 1'b0;

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done_all) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input int cnt, input bit wr, input bit st,
                                     input bit sp, input bit rt, input bit nl);
    logic [31:0] w;
    w = '0; w[15:0] = cnt[15:0]; w[16] = wr; w[17] = 1'b1;
    w[19] = st; w[20] = sp; w[21] = rt; w[25] = nl;
    return w;
  endfunction

  task automatic wr_cmd(input logic [31:0] c);
    cmd_we = 1'b1; cmd_wdata = c; @(negedge clk); cmd_we = 1'b0;
  endtask
  task automatic wr_data(input logic [31:0] d);
    data_we = 1'b1; data_wdata = d; @(negedge clk); data_we = 1'b0;
  endtask
  task automatic run_seg(input logic [31:0] c, input logic [31:0] d);
    wr_cmd(c); wr_data(d); wr_cmd(c | 32'h2000_0000);
  endtask
  task automatic wait_idle();
    for (int t = 0; t < 20000 && run; t++) @(negedge clk);
  endtask
  task automatic clr_all();
    flag_clr = 8'hFF; log_clr = 1'b1; @(negedge clk); flag_clr = '0; log_clr = 1'b0;
  endtask

  // {data word, byte count}: START + transmit + STOP
  localparam logic [34:0] VEC [0:3] = '{
    {32'h3322_11A0, 3'd4},
    {32'h0000_00A0, 3'd1},
    {32'h00BE_EFA0, 3'd3},
    {32'h0000_7EA0, 3'd2}
  };

  initial begin
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 run", run, 0);
    chk("R12 flags", flags, 0);
    chk("R12 status", {got_nak, bus_busy, clk_busy}, 0);
    chk("R12 lines", {scl_w, sda_w}, 2'b11);
    irq_en = 8'h40;

    for (int i = 0; i < 4; i++) begin
      int n;
      n = int'(VEC[i][2:0]);
      clr_all();
      run_seg(mk(n, 1, 1, 1, 0, 0), VEC[i][34:3]);
      if (i == 0) begin
        chk("R1 run high", run, 1);
        chk("R13 clk_busy active", clk_busy, 1);
      end
      wait_idle();
      chk("R1 done flag", flags[6], 1);
      chk("R3 free flag", flags[7], 1);
      chk("R3 lines idle", {scl_w, sda_w, bus_busy}, 3'b110);
      chk("R2 byte count", nlog, n);
      for (int k = 0; k < n; k++)
        chk("R2 byte", rxlog[k], VEC[i][3 + 8*k +: 8]);
      if (i == 0) begin
        chk("R13 clk_busy idle", clk_busy, 0);
        chk("R11 irq on", irq, 1);
        flag_clr = 8'h40; @(negedge clk); flag_clr = '0;
        chk("R11 cleared", {flags[6], irq}, 2'b00);
        chk("R11 other kept", flags[7], 1);
      end
    end

    // read: address segment with retained clock, then receive segment
    clr_all();
    sc = start_cnt;
    run_seg(mk(1, 1, 1, 0, 1, 0), 32'h0000_00A1);
    wait_idle();
    @(negedge clk);
    chk("R4 scl held low", scl_w, 0);
    chk("R4 bus busy", bus_busy, 1);
    wr_data(32'hFFFF_FFFF);
    run_seg(mk(3, 0, 0, 1, 0, 1), 32'hFFFF_FFFF);
    wait_idle();
    chk("R4 no repeated start", start_cnt - sc, 1);
    chk("R5 read data", data_rdata, 32'h007C_6B5A);
    chk("R6 master ack count", nm, 3);
    chk("R6 ack pattern", {mlog[0], mlog[1], mlog[2]}, 3'b001);

    // R10 refused data write while busy
    clr_all();
    run_seg(mk(4, 1, 1, 1, 0, 0), 32'hCAFE_01A0);
    wr_data(32'h1234_5678);
    chk("R10 data unchanged", data_rdata, 32'hCAFE_01A0);
    chk("R10 error flag", flags[0], 1);
    wait_idle();
    chk("R10 bytes sent", {rxlog[3], rxlog[2], rxlog[1], rxlog[0]}, 32'hCAFE_01A0);

    // R7 missing acknowledge
    clr_all();
    nak_at = 1;
    run_seg(mk(3, 1, 1, 1, 0, 0), 32'h0055_44A0);
    wait_idle();
    nak_at = 255;
    chk("R7 got_nak", got_nak, 1);
    chk("R7 nak flag, no done", {flags[5], flags[6]}, 2'b10);
    chk("R7 no stop", bus_busy, 1);
    wr_cmd(mk(1, 1, 1, 1, 0, 0) | 32'h2000_0000);
    chk("R7 run ignored", run, 0);
    repeat (20) @(negedge clk);
    chk("R7 still idle", {run, clk_busy}, 2'b00);
    nak_clr = 1'b1; @(negedge clk); nak_clr = 1'b0;
    chk("R7 nak cleared", got_nak, 0);
    clr_all();
    run_seg(mk(1, 1, 1, 1, 0, 0), 32'h0000_00A0);
    wait_idle();
    chk("R7 recovered", {flags[6], bus_busy}, 2'b10);

    // R9 arbitration loss
    clr_all();
    run_seg(mk(1, 1, 1, 0, 1, 0), 32'h0000_00A0);
    wait_idle();
    jam = 1'b1;
    run_seg(mk(1, 1, 0, 1, 0, 0), 32'h0000_00FF);
    wait_idle();
    chk("R9 arb flag", flags[3], 1);
    chk("R9 released", {run, bus_busy, scl_w, scl_dl, sda_dl}, 5'b00100);
    jam = 1'b0;
    @(negedge clk);

    // R8 early termination
    sc = start_cnt;
    clr_all();
    wr_cmd(mk(0, 1, 1, 1, 0, 0) | 32'h2000_0000);
    chk("R8 count zero", {run, flags[4]}, 2'b01);
    clr_all();
    wr_cmd(mk(5, 1, 1, 1, 0, 0) | 32'h2000_0000);
    chk("R8 count five", {run, flags[4]}, 2'b01);
    clr_all();
    wr_cmd((mk(2, 1, 1, 1, 0, 0) & ~32'h0002_0000) | 32'h2000_0000);
    chk("R8 master off", {run, flags[4]}, 2'b01);
    repeat (30) @(negedge clk);
    chk("R8 no bus activity", {start_cnt - sc, 30'(0), scl_w, sda_w} , {0, 30'(0), 2'b11});

    done_all = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule